// File: doc/BRIEF.md
# Receive Destination Address Filter

This block watches the byte stream of incoming Ethernet frames and decides, from the six destination address bytes at the head of each frame, whether the frame is meant for this station. It can accept a frame because the filter is in promiscuous mode, because the destination equals the programmed station address, because the destination is the all-ones broadcast address, or because a multicast hash bin selected by a CRC-32 of the destination is set. Once per frame that carries at least six bytes, it gives a one-cycle decision pulse with an accept flag and a reason code.

The same stream is copied to the output one cycle later. A frame shorter than the minimum length is followed by zero bytes up to that length, and the input is held off while those bytes go out. The consumer uses the decision to keep or drop the frame. Software sets up the filter through a small write-only port of eight 16-bit registers.

Top module: `rx_addr_filter`

## Requirements
- R1: Configuration register 0 holds the filter controls: bit 0 enables reception, bit 6 selects promiscuous mode and bit 11 enables the hash filter. While bit 0 is clear, every decision has dec_accept 0 and dec_reason 0 (reject), whatever the address.
- R2: With reception enabled and bit 6 set, every frame is accepted with dec_reason 1 and no address is checked.
- R3: Registers 1, 2 and 3 hold station words 0, 1 and 2. Word n holds destination bytes 2n and 2n+1, and the earlier byte is in bits 15:8. A destination equal to all six bytes is accepted with dec_reason 2.
- R4: A destination of six 0xFF bytes that does not match the station is accepted with dec_reason 3. A station match takes priority over broadcast, so a station programmed to all ones reports reason 2.
- R5: When bit 11 is set and neither the station nor the broadcast test matched, the hash index is bits 31:26 of a reflected CRC-32. This CRC uses polynomial 0xEDB88320, starts from 0xFFFFFFFF, is not inverted at the end, and runs over the six destination bytes with the least significant bit of each byte first. Index bits 5:4 select hash word k, which is written at register address 7-k. Index bits 3:0 select the bit in that word. A set bit accepts the frame with dec_reason 4 and a clear bit rejects it.
- R6: With the hash filter disabled, a frame that matches neither the station nor broadcast is rejected with dec_reason 0.
- R7: dec_valid is a single-cycle pulse, high in the second cycle after the clock edge that takes the sixth byte of a frame. There is exactly one pulse per frame that has at least six bytes, and none for shorter frames.
- R8: A frame whose last byte (in_eof) arrives at a total length under MIN_LEN (default 60) is followed on the output by zero bytes up to a total of MIN_LEN, with out_last on the final padding byte. in_ready is low until that byte has been sent.
- R9: Every byte taken at the input (in_valid and in_ready) appears unchanged on out_data in the following cycle. A frame of MIN_LEN or more bytes gets no padding, and out_last marks its own last byte.
- R10: After reset, dec_valid and out_valid are low, in_ready is high, and all configuration registers are zero, so reception is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Input byte is the first byte of a frame |
| in_eof | input | 1 | Input byte is the last byte of a frame |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block can take an input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte (frame data or zero padding) |
| out_last | output | 1 | Output byte is the last byte of the padded frame |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Frame accepted |
| dec_reason | output | 3 | 0 reject, 1 promiscuous, 2 station, 3 broadcast, 4 hash |

## Verification
The bound checker checks on every cycle that the decision pulse lasts one cycle, that the reason code agrees with the accept flag, that each byte taken comes out unchanged one cycle later, and that every byte sent while the input is held off is zero. Whether a particular address is accepted can only be shown by the bench's scenarios, because that depends on the programmed station words, the hash table layout and the CRC value. The same holds for the priority of a station match over broadcast and for the exact number of padding bytes. The bench computes the CRC bit by bit on its own to choose which hash bin to set.

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int          MIN_LEN  = 60,
  parameter int          LEN_W    = 12,
  parameter logic [31:0] CRC_POLY = 32'hEDB88320
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [15:0] cfg_wdata,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_last,
  output logic        dec_valid,
  output logic        dec_accept,
  output logic [2:0]  dec_reason
);
  localparam logic [2:0] RSN_REJECT = 3'd0;
  localparam logic [2:0] RSN_PROMISC = 3'd1;
  localparam logic [2:0] RSN_LOCAL = 3'd2;
  localparam logic [2:0] RSN_BCAST = 3'd3;
  localparam logic [2:0] RSN_HASH = 3'd4;
  localparam int DA_BYTES = 6;
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);

  logic rx_en, promisc, hash_en;
  logic [15:0] sta [3];
  logic [15:0] htab [4];
  logic [47:0] dst;
  logic [31:0] crc;
  logic [LEN_W-1:0] len, pad_idx;
  logic pad, eval;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction

  assign in_ready = !pad;

  wire              take  = in_valid && in_ready;
  wire [LEN_W-1:0]  idx   = in_sof ? '0 : len;
  wire [LEN_W-1:0]  total = idx + 1'b1;
  wire [31:0]       crc_in = in_sof ? 32'hFFFFFFFF : crc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_en <= 1'b0; promisc <= 1'b0; hash_en <= 1'b0;
      for (int i = 0; i < 3; i++) sta[i] <= '0;
      for (int i = 0; i < 4; i++) htab[i] <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == 3'd0) begin
        rx_en   <= cfg_wdata[0];
        promisc <= cfg_wdata[6];
        hash_en <= cfg_wdata[11];
      end else if (!cfg_addr[2]) sta[cfg_addr[1:0] - 2'd1] <= cfg_wdata;
      else htab[2'd3 - cfg_addr[1:0]] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len <= '0; dst <= '0; crc <= '1; eval <= 1'b0;
    end else begin
      eval <= take && (idx == LEN_W'(DA_BYTES - 1));
      if (take) begin
        len <= (&idx) ? idx : total;
        if (idx < LEN_W'(DA_BYTES)) begin
          dst <= {dst[39:0], in_data};
          crc <= crc_byte(crc_in, in_data);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pad <= 1'b0; pad_idx <= '0;
      out_valid <= 1'b0; out_data <= '0; out_last <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      if (pad) begin
        out_valid <= 1'b1;
        out_data  <= '0;
        out_last  <= (pad_idx == MIN_L - 1'b1);
        pad_idx   <= pad_idx + 1'b1;
        if (pad_idx == MIN_L - 1'b1) pad <= 1'b0;
      end else if (take) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
        out_last  <= in_eof && (total >= MIN_L);
        if (in_eof && (total < MIN_L)) begin
          pad     <= 1'b1;
          pad_idx <= total;
        end
      end
    end
  end

  wire [5:0] hidx     = crc[31:26];
  wire       hbit     = htab[hidx[5:4]][hidx[3:0]];
  wire       st_hit   = (dst == {sta[0], sta[1], sta[2]});
  wire       bc_hit   = &dst;
  logic [2:0] reason;

  always_comb begin
    if (!rx_en)                 reason = RSN_REJECT;
    else if (promisc)           reason = RSN_PROMISC;
    else if (st_hit)            reason = RSN_LOCAL;
    else if (bc_hit)            reason = RSN_BCAST;
    else if (hash_en && hbit)   reason = RSN_HASH;
    else                        reason = RSN_REJECT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0; dec_accept <= 1'b0; dec_reason <= RSN_REJECT;
    end else begin
      dec_valid <= eval;
      if (eval) begin
        dec_accept <= (reason != RSN_REJECT);
        dec_reason <= reason;
      end
    end
  end
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_data,
  input logic       in_ready,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       dec_valid,
  input logic       dec_accept,
  input logic [2:0] dec_reason
);
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  assert_reason_matches_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_accept ? (dec_reason >= 3'd1 && dec_reason <= 3'd4) : (dec_reason == 3'd0)));

  assert_byte_passthrough_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

  assert_pad_bytes_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && $past(!in_ready) && $past(rst_n)) |-> (out_valid && out_data == 8'd0));
endmodule

bind rx_addr_filter rx_addr_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
  .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reason(dec_reason)
);

// File: tb/rx_addr_filter_bench.sv
`timescale 1ns/1ps
module rx_addr_filter_bench;
  localparam int MINL = 60;
  localparam int RJ = 0, PR = 1, LO = 2, BC = 3, HS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_last, dec_valid, dec_accept;
  logic [7:0] out_data;
  logic [2:0] dec_reason;

  int checks = 0, errors = 0;
  int dec_cd = -1;
  int exp_reason = 0;
  string cur_req = "R10";
  logic [8:0] exp_q [$];

  always #2.5 clk = ~clk;

  rx_addr_filter u_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reason(dec_reason)
  );

  task automatic check(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (dec_cd > 0) dec_cd--;
      if (dec_cd == 0) begin
        check({cur_req, " R7 decision pulse"}, dec_valid == 1'b1, dec_valid, 1);
        check({cur_req, " reason"}, dec_reason == 3'(exp_reason), dec_reason, exp_reason);
        check({cur_req, " accept"}, dec_accept == (exp_reason != RJ), dec_accept, exp_reason != RJ);
        dec_cd = -1;
      end else begin
        check("R7 no stray decision", dec_valid == 1'b0, dec_valid, 0);
      end
      if (out_valid) begin
        if (exp_q.size() == 0) check("R9 unexpected output byte", 1'b0, out_data, 0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          check("R8/R9 output byte", {out_last, out_data} == e, {out_last, out_data}, e);
        end
      end
    end
  end

  function automatic logic [31:0] model_crc(input logic [47:0] da);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] byt;
      byt = da[47 - 8*b -: 8];
      for (int i = 0; i < 8; i++) begin
        logic fb;
        fb = c[0] ^ byt[i];
        c = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return c;
  endfunction

  task automatic cfg_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_frame(input string req, input logic [47:0] da, input int n, input int reason);
    cur_req = req;
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      @(negedge clk);
      while (!in_ready) begin in_valid = 1'b0; @(negedge clk); end
      b = (i < 6) ? da[47 - 8*i -: 8] : 8'((i * 7 + 3) & 8'hFF);
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == n - 1); in_data = b;
      exp_q.push_back({(i == n - 1) && (n >= MINL), b});
      if (i == n - 1 && n < MINL)
        for (int p = n; p < MINL; p++) exp_q.push_back({p == MINL - 1, 8'h00});
      if (i == 5) begin exp_reason = reason; dec_cd = 2; end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic drain;
    repeat (80) @(negedge clk);
    check({cur_req, " output queue drained"}, exp_q.size() == 0, exp_q.size(), 0);
  endtask

  initial begin
    repeat (500000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] mc;
    logic [5:0] hi;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset dec_valid", dec_valid == 1'b0, dec_valid, 0);
    check("R10 reset out_valid", out_valid == 1'b0, out_valid, 0);
    check("R10 reset in_ready", in_ready == 1'b1, in_ready, 1);

    send_frame("R10 R1 disabled after reset", 48'hFFFFFFFFFFFF, 64, RJ); drain();

    cfg_write(3'd1, 16'h0211); cfg_write(3'd2, 16'h2233); cfg_write(3'd3, 16'h4455);
    cfg_write(3'd0, 16'h0001);
    send_frame("R3 station match", 48'h021122334455, 60, LO); drain();
    send_frame("R4 broadcast", 48'hFFFFFFFFFFFF, 20, BC); drain();
    send_frame("R6 no match hash off", 48'h021122334456, 64, RJ); drain();

    cfg_write(3'd0, 16'h0800);
    send_frame("R1 disabled with hash", 48'h021122334455, 30, RJ); drain();

    mc = 48'h01005E000001;
    hi = model_crc(mc)[31:26];
    cfg_write(3'd0, 16'h0801);
    send_frame("R5 hash bin clear", mc, 61, RJ); drain();
    cfg_write(3'(7 - hi[5:4]), 16'(1) << hi[3:0]);
    send_frame("R5 hash bin set", mc, 61, HS); drain();
    cfg_write(3'(7 - hi[5:4]), ~(16'(1) << hi[3:0]));
    send_frame("R5 other bins only", mc, 40, RJ); drain();

    cfg_write(3'd0, 16'h0041);
    send_frame("R2 promiscuous", 48'h123456789ABC, 15, PR); drain();
    cfg_write(3'd0, 16'h0001);

    cfg_write(3'd1, 16'hFFFF); cfg_write(3'd2, 16'hFFFF); cfg_write(3'd3, 16'hFFFF);
    send_frame("R4 station beats broadcast", 48'hFFFFFFFFFFFF, 12, LO); drain();

    send_frame("R7 R8 four byte frame", 48'hFFFFFFFFFFFF, 4, RJ); drain();
    send_frame("R8 six byte frame", 48'hFFFFFFFFFFFF, 6, LO);
    send_frame("R9 back to back", 48'h0A0B0C0D0E0F, 59, RJ); drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule